// File: doc/BRIEF.md
# Multi-Port GPIO Register Bank

A bank of general-purpose I/O ports behind a simple 32-bit register bus (address, write enable, write data, combinational read data). Each port has 32 pins and its own window of nine word registers: four function-select registers, one data register, two drive-strength registers and two pull-select registers. Software programs a per-pin function code, output level, drive code and pull code. The block turns these into pad controls: output value, output enable, pull-up, pull-down, a 2-bit drive code and the 3-bit function code, which is exported so that alternate-function muxing can be done outside the bank.

Pad inputs are brought in through a two-flop synchronizer. A read of the data register returns the output latch for pins programmed as outputs and the synchronized pad level for every other pin. Writes take effect at the clock edge on which the write enable is sampled; reads are combinational from the address.

Top module: `gpio_bank`

## Requirements
- R1: After reset every register reads 0 and every pad output, output enable, pull-up, pull-down, drive code and function code is 0, so all pins start as inputs with pulls off.
- R2: Port p occupies word addresses 9p to 9p+8 (byte address 0x24·p). Word offsets 0 to 3 hold function select, pin n in word n/8 at bits 4·(n%8)+2 down to 4·(n%8); offset 4 is data, bit n for pin n; offsets 5 and 6 hold drive codes and offsets 7 and 8 hold pull codes, pin n in word 5+n/16 (drive) or 7+n/16 (pull) at bits 2·(n%16)+1 down to 2·(n%16). Written fields read back as written.
- R3: A pin whose function code is 1 has its output enable high; any other code (0 = input, 2 to 7 = alternate) leaves it low. The 3-bit code of pin n appears on pad_func_o bits 3n+2 to 3n of its port.
- R4: Bit 3 of every 4-bit function slot ignores writes and reads 0.
- R5: A write to the data register sets the output latch, which drives pad_out_o from the next cycle whatever the pin function.
- R6: A data register read returns the output latch bit for pins with function code 1 and the synchronized pad input for all others; a pad change set up before clock edge k is first visible after edge k+1.
- R7: Pull code 1 asserts only the pull-up, code 2 only the pull-down, codes 0 and 3 neither; code 3 reads back as 3.
- R8: The drive code of pin n (0 to 3, for 10 to 40 units) is driven on pad_drv_o bits 2n+1 to 2n of its port.
- R9: Addresses past the last port window and addresses with nonzero low two bits read 0, and writes to them change no register or pad output.
- R10: A write to one port leaves every other port's registers and pad outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Byte address |
| we_i | input | 1 | Write enable |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| pad_in_i | input | NUM_PORTS*32 | Pad input levels, port p at bits 32p+31:32p |
| pad_out_o | output | NUM_PORTS*32 | Output latch to pads |
| pad_oe_o | output | NUM_PORTS*32 | Output enable per pin |
| pad_pu_o | output | NUM_PORTS*32 | Pull-up enable per pin |
| pad_pd_o | output | NUM_PORTS*32 | Pull-down enable per pin |
| pad_drv_o | output | NUM_PORTS*64 | Drive code, 2 bits per pin |
| pad_func_o | output | NUM_PORTS*96 | Function code, 3 bits per pin |

## Verification
The synchronizer latency property assumes pad_in_i is a clean two-state level sampled at the clock; the bench changes pad inputs only at the falling edge and holds them for at least two rising edges before it compares a data read. The write-tracking properties assume at most one port is selected per cycle and that addr_i, we_i and wdata_i are stable around the rising edge, which the bench guarantees by driving the bus only at falling edges and lowering we_i one half-cycle after each write.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int BUS_W      = 32;
  localparam int PORT_PINS  = 32;
  localparam int FN_W       = 3;
  localparam int SLOT_W     = 4;
  localparam int DRV_W      = 2;
  localparam int PULL_W     = 2;
  localparam int FN_REGS    = PORT_PINS * SLOT_W / BUS_W;
  localparam int DRV_REGS   = PORT_PINS * DRV_W / BUS_W;
  localparam int PULL_REGS  = PORT_PINS * PULL_W / BUS_W;
  localparam int IDX_DATA   = FN_REGS;
  localparam int IDX_DRV0   = IDX_DATA + 1;
  localparam int IDX_PULL0  = IDX_DRV0 + DRV_REGS;
  localparam int PORT_WORDS = IDX_PULL0 + PULL_REGS;
  localparam int PINS_FN    = BUS_W / SLOT_W;
  localparam int PINS_FLD   = BUS_W / DRV_W;

  localparam logic [FN_W-1:0] FN_OUTPUT = 3'd1;

  typedef enum logic [PULL_W-1:0] {
    PULL_OFF = 2'd0,
    PULL_UP  = 2'd1,
    PULL_DN  = 2'd2,
    PULL_RSV = 2'd3
  } pull_e;

  function automatic logic [BUS_W-1:0] fn_mask();
    logic [BUS_W-1:0] m;
    m = '0;
    for (int s = 0; s < PINS_FN; s++) m[s*SLOT_W +: FN_W] = '1;
    return m;
  endfunction

  localparam logic [BUS_W-1:0] FN_MASK = fn_mask();
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;

  // edges since reset release, saturating, for the latency check
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  AST_SYNC_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2) |-> (q_o == $past(d_i, 2))); // R6
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_bank_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      sel_i,
  input  logic                      we_i,
  input  logic [3:0]                idx_i,
  input  logic [BUS_W-1:0]          wdata_i,
  output logic [BUS_W-1:0]          rdata_o,
  input  logic [PORT_PINS-1:0]      pad_in_i,
  output logic [PORT_PINS-1:0]      pad_out_o,
  output logic [PORT_PINS-1:0]      pad_oe_o,
  output logic [PORT_PINS-1:0]      pad_pu_o,
  output logic [PORT_PINS-1:0]      pad_pd_o,
  output logic [PORT_PINS*DRV_W-1:0] pad_drv_o,
  output logic [PORT_PINS*FN_W-1:0]  pad_func_o
);
  logic [FN_REGS-1:0][BUS_W-1:0]   fn_q;
  logic [BUS_W-1:0]                dat_q;
  logic [DRV_REGS-1:0][BUS_W-1:0]  drv_q;
  logic [PULL_REGS-1:0][BUS_W-1:0] pull_q;
  logic [PORT_PINS-1:0]            in_sync;
  logic [PORT_PINS-1:0]            data_rd;
  logic                            wr;

  assign wr = sel_i & we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fn_q   <= '0;
      dat_q  <= '0;
      drv_q  <= '0;
      pull_q <= '0;
    end else if (wr) begin
      for (int r = 0; r < FN_REGS; r++)
        if (idx_i == 4'(r)) fn_q[r] <= wdata_i & FN_MASK;
      if (idx_i == 4'(IDX_DATA)) dat_q <= wdata_i;
      for (int r = 0; r < DRV_REGS; r++)
        if (idx_i == 4'(IDX_DRV0 + r)) drv_q[r] <= wdata_i;
      for (int r = 0; r < PULL_REGS; r++)
        if (idx_i == 4'(IDX_PULL0 + r)) pull_q[r] <= wdata_i;
    end
  end

  gpio_sync #(.W(PORT_PINS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_in_i),
    .q_o   (in_sync)
  );

  for (genvar n = 0; n < PORT_PINS; n++) begin : g_pin
    localparam int FR = n / PINS_FN;
    localparam int FB = (n % PINS_FN) * SLOT_W;
    localparam int DR = n / PINS_FLD;
    localparam int DB = (n % PINS_FLD) * DRV_W;
    logic [FN_W-1:0]   fcode;
    logic [PULL_W-1:0] pcode;
    assign fcode                  = fn_q[FR][FB +: FN_W];
    assign pcode                  = pull_q[DR][DB +: PULL_W];
    assign pad_func_o[n*FN_W +: FN_W]    = fcode;
    assign pad_oe_o[n]            = (fcode == FN_OUTPUT);
    assign pad_pu_o[n]            = (pcode == PULL_UP);
    assign pad_pd_o[n]            = (pcode == PULL_DN);
    assign pad_drv_o[n*DRV_W +: DRV_W]   = drv_q[DR][DB +: DRV_W];
    assign data_rd[n]             = pad_oe_o[n] ? dat_q[n] : in_sync[n];
  end

  assign pad_out_o = dat_q;

  always_comb begin
    rdata_o = '0;
    if (sel_i) begin
      for (int r = 0; r < FN_REGS; r++)
        if (idx_i == 4'(r)) rdata_o = fn_q[r];
      if (idx_i == 4'(IDX_DATA)) rdata_o = data_rd;
      for (int r = 0; r < DRV_REGS; r++)
        if (idx_i == 4'(IDX_DRV0 + r)) rdata_o = drv_q[r];
      for (int r = 0; r < PULL_REGS; r++)
        if (idx_i == 4'(IDX_PULL0 + r)) rdata_o = pull_q[r];
    end
  end

  AST_DATA_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && idx_i == 4'(IDX_DATA)) |=> (pad_out_o == $past(wdata_i))); // R5
  AST_FUNC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr |=> $stable(pad_func_o)); // R10
  AST_PULL_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_pu_o & pad_pd_o) == '0)); // R7
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && idx_i < 4'(FN_REGS)) |-> ((rdata_o & ~FN_MASK) == '0)); // R4
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int ADDR_W    = 8
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic                             we_i,
  input  logic [BUS_W-1:0]                 wdata_i,
  output logic [BUS_W-1:0]                 rdata_o,
  input  logic [NUM_PORTS*PORT_PINS-1:0]   pad_in_i,
  output logic [NUM_PORTS*PORT_PINS-1:0]   pad_out_o,
  output logic [NUM_PORTS*PORT_PINS-1:0]   pad_oe_o,
  output logic [NUM_PORTS*PORT_PINS-1:0]   pad_pu_o,
  output logic [NUM_PORTS*PORT_PINS-1:0]   pad_pd_o,
  output logic [NUM_PORTS*PORT_PINS*DRV_W-1:0] pad_drv_o,
  output logic [NUM_PORTS*PORT_PINS*FN_W-1:0]  pad_func_o
);
  localparam int WORD_W = ADDR_W - 2;
  localparam int DRV_PP = PORT_PINS * DRV_W;
  localparam int FN_PP  = PORT_PINS * FN_W;

  logic [WORD_W-1:0]                word;
  logic                             aligned;
  logic [NUM_PORTS-1:0]             hit;
  logic [NUM_PORTS-1:0][BUS_W-1:0]  rd;

  assign word    = addr_i[ADDR_W-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam int BASE = p * PORT_WORDS;
    logic [WORD_W-1:0] off;
    assign off    = word - WORD_W'(BASE);
    assign hit[p] = aligned && (int'(word) >= BASE) && (int'(word) < BASE + PORT_WORDS);

    gpio_port u_port (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .sel_i     (hit[p]),
      .we_i      (we_i),
      .idx_i     (4'(off)),
      .wdata_i   (wdata_i),
      .rdata_o   (rd[p]),
      .pad_in_i  (pad_in_i[p*PORT_PINS +: PORT_PINS]),
      .pad_out_o (pad_out_o[p*PORT_PINS +: PORT_PINS]),
      .pad_oe_o  (pad_oe_o[p*PORT_PINS +: PORT_PINS]),
      .pad_pu_o  (pad_pu_o[p*PORT_PINS +: PORT_PINS]),
      .pad_pd_o  (pad_pd_o[p*PORT_PINS +: PORT_PINS]),
      .pad_drv_o (pad_drv_o[p*DRV_PP +: DRV_PP]),
      .pad_func_o(pad_func_o[p*FN_PP +: FN_PP])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int p = 0; p < NUM_PORTS; p++) rdata_o |= rd[p];
  end

  AST_ONE_PORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit)); // R2
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit == '0) |-> (rdata_o == '0)); // R9
  AST_UNMAPPED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit == '0) |=> ($stable(pad_out_o) && $stable(pad_func_o) && $stable(pad_drv_o))); // R9
endmodule

// File: tb/test_gpio_bank.sv
`timescale 1ns/100ps
module test_gpio_bank;
  localparam int NP = 2;
  localparam int PW = 9;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [7:0]        addr = '0;
  logic              we = 1'b0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [NP*32-1:0]  pad_in = '0;
  logic [NP*32-1:0]  pad_out, pad_oe, pad_pu, pad_pd;
  logic [NP*64-1:0]  pad_drv;
  logic [NP*96-1:0]  pad_func;

  gpio_bank #(.NUM_PORTS(NP), .ADDR_W(8)) i_gpio_bank (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe),
    .pad_pu_o(pad_pu), .pad_pd_o(pad_pd), .pad_drv_o(pad_drv), .pad_func_o(pad_func)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [2:0]  fm [NP][32];
  logic [1:0]  drm[NP][32];
  logic [1:0]  pm [NP][32];
  logic [31:0] dm [NP];
  logic [31:0] im [NP];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] v);
    @(negedge clk);
    addr = a; wdata = v; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdata;
  endtask

  function automatic logic [7:0] reg_addr(input int p, input int r);
    return 8'((p * PW + r) * 4);
  endfunction

  function automatic logic [31:0] exp_reg(input int p, input int r);
    logic [31:0] v;
    v = '0;
    if (r < 4) begin
      for (int j = 0; j < 8; j++) v[4*j +: 3] = fm[p][8*r+j];
    end else if (r == 4) begin
      for (int n = 0; n < 32; n++) v[n] = (fm[p][n] == 3'd1) ? dm[p][n] : im[p][n];
    end else if (r < 7) begin
      for (int j = 0; j < 16; j++) v[2*j +: 2] = drm[p][16*(r-5)+j];
    end else begin
      for (int j = 0; j < 16; j++) v[2*j +: 2] = pm[p][16*(r-7)+j];
    end
    return v;
  endfunction

  task automatic wr_reg(input int p, input int r, input logic [31:0] v);
    bus_wr(reg_addr(p, r), v);
    if (r < 4) for (int j = 0; j < 8; j++) fm[p][8*r+j] = v[4*j +: 3];
    else if (r == 4) dm[p] = v;
    else if (r < 7) for (int j = 0; j < 16; j++) drm[p][16*(r-5)+j] = v[2*j +: 2];
    else for (int j = 0; j < 16; j++) pm[p][16*(r-7)+j] = v[2*j +: 2];
  endtask

  task automatic set_in(input int p, input logic [31:0] v);
    @(negedge clk);
    im[p] = v;
    pad_in[p*32 +: 32] = v;
  endtask

  task automatic check_all();
    logic [31:0] v, e_oe, e_pu, e_pd;
    logic [63:0] e_drv;
    logic [95:0] e_fn;
    repeat (2) @(posedge clk);
    for (int p = 0; p < NP; p++) begin
      for (int r = 0; r < PW; r++) begin
        bus_rd(reg_addr(p, r), v);
        if (r < 4) begin
          chk("R2 function readback", v, exp_reg(p, r));
          chk("R4 reserved slot bit", v & 32'h8888_8888, 0);
        end else if (r == 4) chk("R6 data readback", v, exp_reg(p, r));
        else if (r < 7) chk("R8 drive readback", v, exp_reg(p, r));
        else chk("R7 pull readback", v, exp_reg(p, r));
      end
      for (int n = 0; n < 32; n++) begin
        e_oe[n] = (fm[p][n] == 3'd1);
        e_pu[n] = (pm[p][n] == 2'd1);
        e_pd[n] = (pm[p][n] == 2'd2);
        e_drv[2*n +: 2] = drm[p][n];
        e_fn[3*n +: 3] = fm[p][n];
      end
      chk("R3 output enable", pad_oe[p*32 +: 32], e_oe);
      chk("R3 function export lo", pad_func[p*96 +: 48], e_fn[47:0]);
      chk("R3 function export hi", pad_func[p*96+48 +: 48], e_fn[95:48]);
      chk("R5 pad out", pad_out[p*32 +: 32], dm[p]);
      chk("R7 pull-up", pad_pu[p*32 +: 32], e_pu);
      chk("R7 pull-down", pad_pd[p*32 +: 32], e_pd);
      chk("R8 drive export", pad_drv[p*64 +: 64], e_drv);
    end
  endtask

  initial begin
    logic [31:0] pats[7];
    logic [31:0] v, old_in;
    pats = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h1111_1111, 32'h7654_3210,
             32'h89AB_CDEF, 32'hE4E4_E4E4, 32'h1010_2121};
    for (int p = 0; p < NP; p++) begin
      dm[p] = '0; im[p] = '0;
      for (int n = 0; n < 32; n++) begin fm[p][n] = '0; drm[p][n] = '0; pm[p][n] = '0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    @(negedge clk);
    chk("R1 pad out", pad_out, 0);
    chk("R1 output enable", pad_oe, 0);
    chk("R1 pulls", {pad_pu, pad_pd}, 0);
    chk("R1 drive", pad_drv[63:0], 0);
    chk("R1 function", pad_func[63:0], 0);
    for (int p = 0; p < NP; p++)
      for (int r = 0; r < PW; r++) begin
        bus_rd(reg_addr(p, r), v);
        chk("R1 register reset", v, 0);
      end

    // sweep of register patterns over both ports
    for (int k = 0; k < 7; k++) begin
      for (int p = 0; p < NP; p++) begin
        for (int r = 0; r < PW; r++)
          wr_reg(p, r, pats[k] ^ (32'(r) * 32'h1111_1111) ^ (32'(p) * 32'h5A5A_5A5A));
        set_in(p, ~pats[k] ^ 32'(p * 7 + k));
      end
      check_all();
    end

    // R7: reserved pull code on every pin
    wr_reg(0, 7, 32'hFFFF_FFFF);
    wr_reg(0, 8, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R7 code 3 no pull", {pad_pu[31:0], pad_pd[31:0]}, 0);
    bus_rd(reg_addr(0, 7), v);
    chk("R7 code 3 readback", v, 32'hFFFF_FFFF);

    // R5: latch drives pads even for input pins
    for (int r = 0; r < 4; r++) wr_reg(0, r, 32'h0);
    wr_reg(0, 4, 32'hC3A5_5A3C);
    @(negedge clk);
    chk("R5 latch to pads, inputs", pad_out[31:0], 32'hC3A5_5A3C);
    chk("R3 no enable for inputs", pad_oe[31:0], 0);

    // R6: two-edge synchronizer latency
    set_in(0, 32'h0F0F_0F0F);
    repeat (3) @(posedge clk);
    old_in = 32'h0F0F_0F0F;
    set_in(0, 32'hF0F0_1234);
    bus_rd(reg_addr(0, 4), v);
    chk("R6 one edge still old", v, old_in);
    bus_rd(reg_addr(0, 4), v);
    chk("R6 two edges new", v, 32'hF0F0_1234);

    // R6: output pins read latch, not pad
    wr_reg(0, 0, 32'h1111_1111);
    check_all();

    // R9: unmapped and misaligned accesses
    for (int w = NP * PW; w < 64; w++) begin
      bus_wr(8'(w * 4), 32'hFFFF_FFFF);
      bus_rd(8'(w * 4), v);
      chk("R9 unmapped reads 0", v, 0);
    end
    bus_wr(8'h11, 32'hFFFF_FFFF);
    bus_rd(8'h11, v);
    chk("R9 misaligned reads 0", v, 0);
    for (int p = 0; p < NP; p++)
      for (int r = 0; r < PW; r++) begin
        bus_rd(reg_addr(p, r), v);
        chk("R9 no effect of unmapped write", v, exp_reg(p, r));
      end
    check_all();

    // R10: port isolation
    for (int r = 0; r < PW; r++) wr_reg(1, r, 32'h3CC3_A55A ^ 32'(r));
    for (int r = 0; r < PW; r++) begin
      bus_rd(reg_addr(0, r), v);
      chk("R10 other port untouched", v, exp_reg(0, r));
    end
    check_all();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule